// File: doc/BRIEF.md
# Backplane Command Engine with Polled Result Collection

This block sits between a decoded host command stream and a shared backplane bus with a single master, serving up to 20 plug-in modules of 6 compute devices each. Each host command arrives on a valid/ready port. The engine then runs the bus cycles the command needs, and returns one or more responses on a second valid/ready port. The bus has a 16-bit address, a 64-bit bidirectional data path, separate read and write strobes, one chip select per device and a backplane reset line. There is one master, so no arbitration exists. Devices raise no interrupts: results are found only by polling.

A host first loads configuration into all devices, into every device of one module, or into one device. It then writes operands and issues a start. After that it repeatedly orders a poll pass, which reads a status word from every device in ascending order. A device shows up in the response stream only if it reports a finished result. Back-pressure rules: a command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the engine is idle. A response is held unchanged on the output until `rsp_ready` takes it. While a response waits, the engine stalls and issues no further bus cycle.

Top module: `bpl_cmd_ctrl`

## Requirements
- R1: `cmd_ready` is high only when no command is in progress, including out of reset. Each command produces exactly one response, except a poll, which produces zero or more hit responses followed by one end-of-pass response.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_kind`, `rsp_addr` and `rsp_data` keep their values. Response kinds are 0 acknowledge, 1 read data, 2 poll hit, 3 end of pass and 4 error.
- R3: The bus address is {slot[15:11], device[10:8], register[7:0]}. The chip select of slot s, device d is bit s*6+d of `bus_cs`.
- R4: A write holds `bus_wr` high for exactly one cycle. In that cycle it drives the data bus and asserts the chip selects of the target: 0 one device, 1 all six devices of the slot, 2 every device.
- R5: Device codes 6 and 7, and slot numbers of 20 or more, select no device. A write to such an address still runs with no chip select and is acknowledged, with the bus address as `rsp_addr`. A read to such an address returns error.
- R6: A read with a target other than one device (code 0) is rejected with an error response. The error response carries the command address, and no bus cycle is run.
- R7: A read holds `bus_rd` high for one cycle with exactly one chip select. The engine leaves the data bus undriven during that cycle and the next one. It captures the data at the end of the next cycle and returns it as kind 1 with the bus address.
- R8: Op 1 (program) writes `cmd_data` to register 0x01. Op 3 (start) writes the value 1 to register 0x02. Op 2 (write) writes `cmd_data` to `cmd_reg`. Op 4 (read) reads `cmd_reg`.
- R9: Op 5 (poll) reads register 0x03 of every valid device, with the slot as the outer loop and the device as the inner loop, both ascending. It emits kind 2 carrying the address and status word whenever status bit 0 (result) or bit 1 (done) is set. It ends with kind 3, address 0 and data 0.
- R10: Op 0 (reset) holds `bus_rst` high for RST_CYC cycles (default 4) with no strobe. It then acknowledges with address 0.
- R11: Op codes 6 and 7 return an error response and run no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_op | input | 3 | Operation code |
| cmd_tgt | input | 2 | Target mode: one, slot, all |
| cmd_slot | input | 5 | Slot number |
| cmd_dev | input | 3 | Device within slot |
| cmd_reg | input | 8 | Device register offset |
| cmd_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Host accepts response |
| rsp_kind | output | 3 | Response kind |
| rsp_addr | output | 16 | Bus address the response refers to |
| rsp_data | output | 64 | Read data or status word |
| bus_addr | output | 16 | Backplane address |
| bus_dq | inout | 64 | Backplane data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_cs | output | 120 | One chip select per device |
| bus_rst | output | 1 | Backplane reset |

## Verification
A poll pass and response back-pressure can meet in the same cycle: a status read completes while the host is refusing the previous hit. The bench provokes this by dropping `rsp_ready` before a poll over a device array with several flagged devices, then holding it low for many cycles while a new command waits. The scoreboard then expects the engine to freeze with the held response unchanged and `cmd_ready` low. Once the host accepts again, the remaining hits must arrive in ascending device order with no hit lost or repeated.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_PROG  = 3'd1,
    OP_WRITE = 3'd2,
    OP_START = 3'd3,
    OP_READ  = 3'd4,
    OP_POLL  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    TG_ONE = 2'd0,
    TG_MOD = 2'd1,
    TG_ALL = 2'd2
  } tgt_e;

  typedef enum logic [2:0] {
    RK_ACK   = 3'd0,
    RK_RDATA = 3'd1,
    RK_HIT   = 3'd2,
    RK_PEND  = 3'd3,
    RK_ERR   = 3'd4
  } rsp_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DISP, ST_ISSUE, ST_WAIT, ST_RST,
    ST_PISSUE, ST_PWAIT, ST_PHIT, ST_PNEXT, ST_RESP
  } st_e;

  localparam logic [7:0] REG_CFG  = 8'h01;
  localparam logic [7:0] REG_GO   = 8'h02;
  localparam logic [7:0] REG_STAT = 8'h03;
  localparam int STAT_RES_BIT  = 0;
  localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/bpl_sel_decode.sv
module bpl_sel_decode
  import bpl_pkg::*;
#(
  parameter int N_SLOT  = 20,
  parameter int DEV_PER = 6,
  parameter int SLOT_W  = 5,
  parameter int DEV_W   = 3,
  parameter int N_DEV   = N_SLOT * DEV_PER
) (
  input  tgt_e              tgt,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DEV_W-1:0]  dev,
  output logic [N_DEV-1:0]  cs,
  output logic              one_ok
);
  assign one_ok = ({1'b0, slot} < (SLOT_W+1)'(N_SLOT)) &&
                  ({1'b0, dev}  < (DEV_W+1)'(DEV_PER));

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    for (genvar d = 0; d < DEV_PER; d++) begin : g_dev
      assign cs[s*DEV_PER + d] =
        (tgt == TG_ALL) ||
        ((slot == SLOT_W'(s)) &&
         ((tgt == TG_MOD) || ((tgt == TG_ONE) && (dev == DEV_W'(d)))));
    end
  end
endmodule

// File: rtl/bpl_bus_access.sv
module bpl_bus_access #(
  parameter int AW    = 16,
  parameter int DW    = 64,
  parameter int N_DEV = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_DEV-1:0] cs_i,
  output logic [AW-1:0]    bus_addr,
  output logic [N_DEV-1:0] bus_cs,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             dq_oe,
  output logic [DW-1:0]    dq_out,
  input  logic [DW-1:0]    dq_in,
  output logic             done,
  output logic [DW-1:0]    rdata
);
  typedef enum logic [1:0] {AC_IDLE, AC_WR, AC_RD, AC_CAP} ac_e;
  ac_e ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= AC_IDLE;
      bus_addr <= '0;
      bus_cs   <= '0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        AC_IDLE: begin
          if (start) begin
            bus_addr <= addr_i;
            bus_cs   <= cs_i;
            if (is_read) begin
              bus_rd <= 1'b1;
              ph     <= AC_RD;
            end else begin
              bus_wr <= 1'b1;
              dq_oe  <= 1'b1;
              dq_out <= wdata_i;
              ph     <= AC_WR;
            end
          end
        end
        AC_WR: begin
          bus_wr   <= 1'b0;
          dq_oe    <= 1'b0;
          bus_cs   <= '0;
          bus_addr <= '0;
          done     <= 1'b1;
          ph       <= AC_IDLE;
        end
        AC_RD: begin
          bus_rd <= 1'b0;
          ph     <= AC_CAP;
        end
        default: begin
          rdata    <= dq_in;
          bus_cs   <= '0;
          bus_addr <= '0;
          done     <= 1'b1;
          ph       <= AC_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bpl_rsp_stage.sv
module bpl_rsp_stage #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_kind,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind <= in_kind;
        out_addr <= in_addr;
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/bpl_cmd_ctrl.sv
module bpl_cmd_ctrl
  import bpl_pkg::*;
#(
  parameter int N_SLOT  = 20,
  parameter int DEV_PER = 6,
  parameter int SLOT_W  = 5,
  parameter int DEV_W   = 3,
  parameter int REG_W   = 8,
  parameter int DW      = 64,
  parameter int RST_CYC = 4,
  parameter int AW      = SLOT_W + DEV_W + REG_W,
  parameter int N_DEV   = N_SLOT * DEV_PER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_tgt,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DW-1:0]     cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_kind,
  output logic [AW-1:0]     rsp_addr,
  output logic [DW-1:0]     rsp_data,
  output logic [AW-1:0]     bus_addr,
  inout  wire  [DW-1:0]     bus_dq,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [N_DEV-1:0]  bus_cs,
  output logic              bus_rst
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  st_e               st;
  op_e               c_op;
  tgt_e              c_tgt;
  logic [SLOT_W-1:0] c_slot, p_slot;
  logic [DEV_W-1:0]  c_dev, p_dev;
  logic [REG_W-1:0]  c_reg;
  logic [DW-1:0]     c_data;
  logic [RC_W-1:0]   rcnt;
  rsp_e              pk;
  logic [AW-1:0]     pa;
  logic [DW-1:0]     pd;
  logic              bus_rst_q;

  logic              polling;
  tgt_e              sel_tgt;
  logic [SLOT_W-1:0] sel_slot;
  logic [DEV_W-1:0]  sel_dev;
  logic [REG_W-1:0]  sel_reg;
  logic [DW-1:0]     sel_wdata;
  logic [AW-1:0]     acc_addr;
  logic [N_DEV-1:0]  dec_cs;
  logic              one_ok;
  logic              acc_start, acc_read, acc_done;
  logic [DW-1:0]     acc_rdata;
  logic              dq_oe;
  logic [DW-1:0]     dq_out;
  logic              rsp_in_valid, rsp_in_ready;
  logic              last_dev;

  assign polling  = (c_op == OP_POLL);
  assign sel_tgt  = polling ? TG_ONE : c_tgt;
  assign sel_slot = polling ? p_slot : c_slot;
  assign sel_dev  = polling ? p_dev  : c_dev;

  always_comb begin
    case (c_op)
      OP_PROG:  sel_reg = REG_W'(REG_CFG);
      OP_START: sel_reg = REG_W'(REG_GO);
      OP_POLL:  sel_reg = REG_W'(REG_STAT);
      default:  sel_reg = c_reg;
    endcase
  end

  assign sel_wdata = (c_op == OP_START) ? DW'(1) : c_data;
  assign acc_addr  = {sel_slot, sel_dev, sel_reg};
  assign acc_start = (st == ST_ISSUE) || (st == ST_PISSUE);
  assign acc_read  = (c_op == OP_READ) || polling;
  assign cmd_ready = (st == ST_IDLE);
  assign rsp_in_valid = (st == ST_RESP) || (st == ST_PHIT);
  assign last_dev  = (p_slot == SLOT_W'(N_SLOT - 1)) && (p_dev == DEV_W'(DEV_PER - 1));
  assign bus_rst   = bus_rst_q;
  assign bus_dq    = dq_oe ? dq_out : {DW{1'bz}};

  bpl_sel_decode #(
    .N_SLOT(N_SLOT), .DEV_PER(DEV_PER), .SLOT_W(SLOT_W), .DEV_W(DEV_W), .N_DEV(N_DEV)
  ) u_dec (
    .tgt(sel_tgt), .slot(sel_slot), .dev(sel_dev), .cs(dec_cs), .one_ok(one_ok)
  );

  bpl_bus_access #(.AW(AW), .DW(DW), .N_DEV(N_DEV)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .is_read(acc_read),
    .addr_i(acc_addr), .wdata_i(sel_wdata), .cs_i(dec_cs),
    .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(bus_dq),
    .done(acc_done), .rdata(acc_rdata)
  );

  bpl_rsp_stage #(.AW(AW), .DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rsp_in_valid), .in_ready(rsp_in_ready),
    .in_kind(pk), .in_addr(pa), .in_data(pd),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_kind(rsp_kind), .out_addr(rsp_addr), .out_data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      c_op      <= OP_RESET;
      c_tgt     <= TG_ONE;
      c_slot    <= '0;
      c_dev     <= '0;
      c_reg     <= '0;
      c_data    <= '0;
      p_slot    <= '0;
      p_dev     <= '0;
      rcnt      <= '0;
      pk        <= RK_ACK;
      pa        <= '0;
      pd        <= '0;
      bus_rst_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            c_op   <= op_e'(cmd_op);
            c_tgt  <= tgt_e'(cmd_tgt);
            c_slot <= cmd_slot;
            c_dev  <= cmd_dev;
            c_reg  <= cmd_reg;
            c_data <= cmd_data;
            st     <= ST_DISP;
          end
        end
        ST_DISP: begin
          case (c_op)
            OP_RESET: begin
              rcnt      <= '0;
              bus_rst_q <= 1'b1;
              st        <= ST_RST;
            end
            OP_PROG, OP_WRITE, OP_START: st <= ST_ISSUE;
            OP_READ: begin
              if (c_tgt == TG_ONE && one_ok) begin
                st <= ST_ISSUE;
              end else begin
                pk <= RK_ERR;
                pa <= acc_addr;
                pd <= '0;
                st <= ST_RESP;
              end
            end
            OP_POLL: begin
              p_slot <= '0;
              p_dev  <= '0;
              st     <= ST_PISSUE;
            end
            default: begin
              pk <= RK_ERR;
              pa <= acc_addr;
              pd <= '0;
              st <= ST_RESP;
            end
          endcase
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (acc_done) begin
            pa <= acc_addr;
            pk <= acc_read ? RK_RDATA : RK_ACK;
            pd <= acc_read ? acc_rdata : '0;
            st <= ST_RESP;
          end
        end
        ST_RST: begin
          if (rcnt == RC_W'(RST_CYC - 1)) begin
            bus_rst_q <= 1'b0;
            pk        <= RK_ACK;
            pa        <= '0;
            pd        <= '0;
            st        <= ST_RESP;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_PISSUE: st <= ST_PWAIT;
        ST_PWAIT: begin
          if (acc_done) begin
            if (acc_rdata[STAT_RES_BIT] || acc_rdata[STAT_DONE_BIT]) begin
              pk <= RK_HIT;
              pa <= acc_addr;
              pd <= acc_rdata;
              st <= ST_PHIT;
            end else begin
              st <= ST_PNEXT;
            end
          end
        end
        ST_PHIT: if (rsp_in_ready) st <= ST_PNEXT;
        ST_PNEXT: begin
          if (last_dev) begin
            pk <= RK_PEND;
            pa <= '0;
            pd <= '0;
            st <= ST_RESP;
          end else begin
            if (p_dev == DEV_W'(DEV_PER - 1)) begin
              p_dev  <= '0;
              p_slot <= p_slot + 1'b1;
            end else begin
              p_dev <= p_dev + 1'b1;
            end
            st <= ST_PISSUE;
          end
        end
        default: if (rsp_in_ready) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bpl_cmd_ctrl_chk.sv
module bpl_cmd_ctrl_chk #(
  parameter int AW    = 16,
  parameter int DW    = 64,
  parameter int N_DEV = 120
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_kind,
  input logic [AW-1:0]    rsp_addr,
  input logic [DW-1:0]    rsp_data,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [N_DEV-1:0] bus_cs,
  input logic             bus_rst,
  input logic             dq_oe
);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || bus_rst) |-> !cmd_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) &&
                                   $stable(rsp_addr) && $stable(rsp_data)));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  p_wr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> dq_oe);

  p_rd_onecs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> ($countones(bus_cs) == 1));

  p_rd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !dq_oe);

  p_rd_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (!bus_rd && !dq_oe && $stable(bus_addr)));

  p_rst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (!bus_rd && !bus_wr));
endmodule

bind bpl_cmd_ctrl bpl_cmd_ctrl_chk #(.AW(AW), .DW(DW), .N_DEV(N_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
  .rsp_addr(rsp_addr), .rsp_data(rsp_data), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cs(bus_cs), .bus_rst(bus_rst),
  .dq_oe(dq_oe)
);

// File: tb/tb_bpl_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_bpl_cmd_ctrl;
  localparam int NS = 20;
  localparam int ND = 6;
  localparam int NDEV = NS * ND;

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [63:0] data;
    string       tag;
  } rsp_t;

  typedef struct {
    logic [NDEV-1:0] cs;
    logic [15:0]     addr;
    logic [63:0]     data;
    string           tag;
  } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_tgt = '0;
  logic [4:0] cmd_slot = '0;
  logic [2:0] cmd_dev = '0;
  logic [7:0] cmd_reg = '0;
  logic [63:0] cmd_data = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [2:0] rsp_kind;
  logic [15:0] rsp_addr;
  logic [63:0] rsp_data;
  logic [15:0] bus_addr;
  wire  [63:0] bus_dq;
  logic bus_rd, bus_wr, bus_rst;
  logic [NDEV-1:0] bus_cs;

  logic drv_en = 1'b0;
  logic [63:0] drv_val = '0;
  logic [63:0] status [NDEV];
  int rd_count = 0;
  int rst_hi = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;
  rsp_t rq[$];
  wr_t  wq[$];

  assign bus_dq = drv_en ? drv_val : 64'bz;

  always #2.5 clk = ~clk;

  bpl_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_tgt(cmd_tgt), .cmd_slot(cmd_slot), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .bus_addr(bus_addr), .bus_dq(bus_dq), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_cs(bus_cs), .bus_rst(bus_rst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(int s, int d, int r);
    return {5'(s), 3'(d), 8'(r)};
  endfunction

  function automatic logic [NDEV-1:0] cs_of(int tgt, int s, int d);
    logic [NDEV-1:0] v = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (tgt == 2) v[i] = 1'b1;
      else if (tgt == 1 && (i / ND) == s) v[i] = 1'b1;
      else if (tgt == 0 && (i / ND) == s && (i % ND) == d && d < ND) v[i] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [63:0] rd_val(int idx, logic [7:0] r);
    if (r == 8'h03) return status[idx];
    return {32'hC0DE0000 | 32'(idx), 24'h0, r};
  endfunction

  task automatic exp_rsp(input logic [2:0] k, input logic [15:0] a,
                         input logic [63:0] d, input string tag);
    rsp_t e;
    e.kind = k; e.addr = a; e.data = d; e.tag = tag;
    rq.push_back(e);
  endtask

  task automatic exp_wr(input logic [NDEV-1:0] cs, input logic [15:0] a,
                        input logic [63:0] d, input string tag);
    wr_t e;
    e.cs = cs; e.addr = a; e.data = d; e.tag = tag;
    wq.push_back(e);
  endtask

  task automatic send(input int op, input int tgt, input int s, input int d,
                      input int r, input logic [63:0] data);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_tgt = 2'(tgt);
    cmd_slot = 5'(s); cmd_dev = 3'(d); cmd_reg = 8'(r); cmd_data = data;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (rq.size() != 0 || wq.size() != 0 || !cmd_ready);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Device model: answers a read strobe during the following cycle
  always @(posedge clk) begin
    if (bus_rd) begin
      int hit;
      hit = 0;
      for (int i = 0; i < NDEV; i++) if (bus_cs[i]) hit = i;
      drv_val <= rd_val(hit, bus_addr[7:0]);
      drv_en  <= 1'b1;
      rd_count++;
    end else begin
      drv_en <= 1'b0;
    end
  end

  // Bus write monitor (R3, R4, R8)
  always @(negedge clk) begin
    if (rst_n && bus_rst) rst_hi++;
    if (rst_n && bus_wr) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R4", "unexpected write", 128'(bus_addr), 128'h0);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk(bus_cs == e.cs, e.tag, "write cs", 128'(bus_cs), 128'(e.cs));
        chk(bus_addr == e.addr, e.tag, "write addr", 128'(bus_addr), 128'(e.addr));
        chk(bus_dq === e.data, e.tag, "write data", 128'(bus_dq), 128'(e.data));
      end
    end
    if (rst_n && bus_rd)
      chk(bus_dq === 64'bz, "R7", "bus driven in read cycle", 128'(bus_dq), 128'h0);
  end

  // Response scoreboard and hold monitor (R1, R2)
  logic held = 1'b0;
  logic [2:0] h_kind;
  logic [15:0] h_addr;
  logic [63:0] h_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        chk(rsp_valid && rsp_kind == h_kind && rsp_addr == h_addr && rsp_data == h_data,
            "R2", "held response changed", {rsp_kind, rsp_addr, rsp_data},
            {h_kind, h_addr, h_data});
      held   = rsp_valid && !rsp_ready;
      h_kind = rsp_kind; h_addr = rsp_addr; h_data = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R1", "unexpected response", 128'(rsp_kind), 128'h0);
        end else begin
          rsp_t e;
          e = rq.pop_front();
          chk(rsp_kind == e.kind, e.tag, "kind", 128'(rsp_kind), 128'(e.kind));
          chk(rsp_addr == e.addr, e.tag, "addr", 128'(rsp_addr), 128'(e.addr));
          chk(rsp_data == e.data, e.tag, "data", 128'(rsp_data), 128'(e.data));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 128'(rq.size()), 128'h0);
    finish_run();
  end

  initial begin
    int r0;
    for (int i = 0; i < NDEV; i++) status[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !rsp_valid && !bus_rd && !bus_wr && !bus_rst && bus_cs == '0,
        "R1", "reset state", {cmd_ready, rsp_valid, bus_rd, bus_wr, bus_rst},
        128'h10);

    // R4 R8 program to all devices
    exp_wr(cs_of(2, 4, 1), mk_addr(4, 1, 8'h01), 64'h1111_2222_3333_4444, "R4");
    exp_rsp(3'd0, mk_addr(4, 1, 8'h01), '0, "R8");
    send(1, 2, 4, 1, 8'hEE, 64'h1111_2222_3333_4444);
    // R4 program one module (slot 3 -> bits 18..23)
    exp_wr(cs_of(1, 3, 0), mk_addr(3, 0, 8'h01), 64'hABCD, "R4");
    exp_rsp(3'd0, mk_addr(3, 0, 8'h01), '0, "R4");
    send(1, 1, 3, 0, 0, 64'hABCD);
    // R3 write one device at the top corner
    exp_wr(cs_of(0, 19, 5), mk_addr(19, 5, 8'h40), 64'hFEED_0000_0000_BEEF, "R3");
    exp_rsp(3'd0, mk_addr(19, 5, 8'h40), '0, "R3");
    send(2, 0, 19, 5, 8'h40, 64'hFEED_0000_0000_BEEF);
    // R8 start writes value 1 to register 0x02
    exp_wr(cs_of(0, 0, 0), mk_addr(0, 0, 8'h02), 64'd1, "R8");
    exp_rsp(3'd0, mk_addr(0, 0, 8'h02), '0, "R8");
    send(3, 0, 0, 0, 8'h77, 64'h9999);
    // R5 write to device code 6: no select, still acknowledged
    exp_wr('0, mk_addr(2, 6, 8'h10), 64'h55, "R5");
    exp_rsp(3'd0, mk_addr(2, 6, 8'h10), '0, "R5");
    send(2, 0, 2, 6, 8'h10, 64'h55);
    wait_idle();

    // R7 single read
    exp_rsp(3'd1, mk_addr(7, 2, 8'h10), rd_val(44, 8'h10), "R7");
    send(4, 0, 7, 2, 8'h10, '0);
    wait_idle();

    // R6 R5 R11 rejected reads and codes
    r0 = rd_count;
    exp_rsp(3'd4, mk_addr(1, 1, 8'h10), '0, "R6");
    send(4, 2, 1, 1, 8'h10, '0);
    exp_rsp(3'd4, mk_addr(1, 7, 8'h10), '0, "R5");
    send(4, 0, 1, 7, 8'h10, '0);
    exp_rsp(3'd4, mk_addr(25, 0, 8'h10), '0, "R5");
    send(4, 0, 25, 0, 8'h10, '0);
    exp_rsp(3'd4, mk_addr(2, 2, 8'h05), '0, "R11");
    send(6, 0, 2, 2, 8'h05, '0);
    wait_idle();
    chk(rd_count == r0, "R6", "no bus read on reject", 128'(rd_count), 128'(r0));

    // R10 reset
    rst_hi = 0;
    exp_rsp(3'd0, 16'h0, '0, "R10");
    send(0, 0, 0, 0, 0, '0);
    wait_idle();
    chk(rst_hi == 4, "R10", "reset cycles", 128'(rst_hi), 128'd4);

    // R9 poll with a few flagged devices
    status[0] = 64'h1; status[13] = 64'h2; status[50] = 64'h20;
    status[77] = 64'hA5_0001; status[119] = 64'h3;
    for (int i = 0; i < NDEV; i++)
      if (status[i][1:0] != 0) exp_rsp(3'd2, mk_addr(i / ND, i % ND, 8'h03), status[i], "R9");
    exp_rsp(3'd3, 16'h0, '0, "R9");
    r0 = rd_count;
    send(5, 0, 0, 0, 0, '0);
    wait_idle();
    chk(rd_count == r0 + NDEV, "R9", "reads per pass", 128'(rd_count), 128'(r0 + NDEV));

    // R2 R1 poll under back-pressure
    status[0] = '0; status[6] = 64'h1; status[7] = 64'h2; status[8] = 64'h1;
    for (int i = 0; i < NDEV; i++)
      if (status[i][1:0] != 0) exp_rsp(3'd2, mk_addr(i / ND, i % ND, 8'h03), status[i], "R2");
    exp_rsp(3'd3, 16'h0, '0, "R9");
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(5, 0, 0, 0, 0, '0);
    repeat (80) @(negedge clk);
    chk(rsp_valid, "R2", "response held", 128'(rsp_valid), 128'd1);
    chk(!cmd_ready, "R1", "busy while stalled", 128'(cmd_ready), 128'd0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_idle();
    // R1 next command after poll
    exp_rsp(3'd1, mk_addr(1, 0, 8'h03), 64'h1, "R1");
    send(4, 0, 1, 0, 8'h03, '0);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(rq.size() == 0 && wq.size() == 0, "R1", "queues drained",
        128'(rq.size() + wq.size()), 128'd0);
    finish_run();
  end
endmodule